// File: doc/BRIEF.md
# DMA Transfer-Length Tracker

This block keeps track of how many bytes remain in a serial port's DMA receive and transmit transfers. Software loads a 32-bit length for each direction through a small register port. While the port runs in DMA mode, each byte strobe from the data path lowers that direction's count by one. When the count runs out, a sticky done flag is raised and a per-direction "transfer allowed" output falls, so the data path stops moving bytes. A count of all ones is a sentinel for an endless transfer: the count then never moves and never finishes.

The block also holds the ingress and egress DMA socket numbers and drives them out to the DMA fabric. Register writes take effect in one cycle. Reads return data one cycle after the request.

Top module: `xfer_len_tracker`

## Requirements
- R1: After a synchronous reset, both counts read 0xFFFFFFFF, both socket fields are 0, both done flags are 0, both allowed outputs are 1, and `reg_rdata` is 0.
- R2: A count holding 0xFFFFFFFF stays at that value under byte strobes, and its done flag is never raised from it.
- R3: With `dma_mode` high, each cycle in which a direction's byte strobe is high and its count is neither 0 nor all ones lowers that count by exactly one.
- R4: A direction's done flag is set only when a strobe lowers its count from 1 to 0. It stays set until cleared. A software write of 0 to a count does not set it.
- R5: With `dma_mode` low, byte strobes leave both counts and both done flags unchanged.
- R6: When a software write to a count register and a strobe for that direction fall in the same cycle, the count takes the written value, and no decrement or done-set happens that cycle.
- R7: While a count is 0, that direction's allowed output is 0 and strobes leave the count at 0 without wrapping. Loading a non-zero count raises the allowed output on the next cycle.
- R8: The status register sits at offset 0xC, with bit 0 as the receive done flag and bit 1 as the transmit done flag. Writing 1 to a bit clears it and writing 0 has no effect. If a set and a clear hit the same flag in one cycle, the set wins.
- R9: The socket register sits at offset 0x0, with the egress socket in bits 7:0 and the ingress socket in bits 15:8. Both fields drive their output ports, and bits 31:16 read as 0.
- R10: The receive count sits at offset 0x4 and the transmit count at offset 0x8. Both are writable and readable. A read raises `reg_rvalid`, and `reg_rdata` holds the value on the cycle after `reg_rd_en`.
- R11: The two directions are independent: one direction's strobes, loads and clears never change the other direction's count or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_mode | input | 1 | High when the serial port moves data through DMA |
| rx_byte_stb | input | 1 | One received byte moved this cycle |
| tx_byte_stb | input | 1 | One transmitted byte moved this cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd_en` |
| egress_sock | output | 8 | Egress DMA socket number |
| ingress_sock | output | 8 | Ingress DMA socket number |
| rx_allow | output | 1 | Receive path may move more bytes |
| tx_allow | output | 1 | Transmit path may move more bytes |
| rx_done | output | 1 | Sticky receive-finished flag |
| tx_done | output | 1 | Sticky transmit-finished flag |

## Verification
Two functions can act on the same state in one cycle. The first pair is a software reload of a count and a hardware decrement of that same count. The second pair is a write-one-to-clear on a done flag and the decrement that sets that flag. The bench lines up a register write and a byte strobe on the same clock edge. For the first pair, it expects the written count to survive with the done flag still low. For the second pair, it expects the done flag to stay set. Both outcomes are checked through the register port and the flag outputs on the following cycle.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  // Channel indices
  localparam int unsigned CH_RX = 0;
  localparam int unsigned CH_TX = 1;
  localparam int unsigned N_CH  = 2;

  // Register byte offsets
  localparam int unsigned OFS_SOCK  = 'h0;
  localparam int unsigned OFS_RXCNT = 'h4;
  localparam int unsigned OFS_TXCNT = 'h8;
  localparam int unsigned OFS_STAT  = 'hC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SOCK,
    SEL_RXCNT,
    SEL_TXCNT,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/xlt_chan.sv
module xlt_chan #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dma_mode,
  input  logic             byte_stb,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             clr_done,
  output logic [CNT_W-1:0] cnt,
  output logic             done,
  output logic             allow
);
  localparam logic [CNT_W-1:0] ENDLESS = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             done_q, allow_q;
  logic             dec_ok, hit_zero;

  always_comb begin
    dec_ok   = dma_mode && byte_stb && (cnt_q != ENDLESS) && (cnt_q != '0);
    hit_zero = !ld_en && dec_ok && (cnt_q == ONE);
    if (ld_en)       cnt_nxt = ld_val;
    else if (dec_ok) cnt_nxt = cnt_q - ONE;
    else             cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= ENDLESS;
      done_q  <= 1'b0;
      allow_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_nxt;
      allow_q <= (cnt_nxt != '0);
      if (hit_zero)      done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
    end
  end

  assign cnt   = cnt_q;
  assign done  = done_q;
  assign allow = allow_q;
endmodule

// File: rtl/xlt_regif.sv
module xlt_regif
  import xlt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned SOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  rx_cnt,
  input  logic [CNT_W-1:0]  tx_cnt,
  input  logic              rx_done,
  input  logic              tx_done,
  output logic              rx_ld,
  output logic              tx_ld,
  output logic              rx_clr,
  output logic              tx_clr,
  output logic [SOCK_W-1:0] egress,
  output logic [SOCK_W-1:0] ingress,
  output logic [CNT_W-1:0]  rdata,
  output logic              rvalid
);
  localparam int unsigned SOCK_HI = 2 * SOCK_W;

  reg_sel_e          sel;
  logic [SOCK_W-1:0] egress_q, ingress_q;
  logic [CNT_W-1:0]  rd_mux, rdata_q;
  logic              rvalid_q;

  always_comb begin
    if      (addr == ADDR_W'(OFS_SOCK))  sel = SEL_SOCK;
    else if (addr == ADDR_W'(OFS_RXCNT)) sel = SEL_RXCNT;
    else if (addr == ADDR_W'(OFS_TXCNT)) sel = SEL_TXCNT;
    else if (addr == ADDR_W'(OFS_STAT))  sel = SEL_STAT;
    else                                 sel = SEL_NONE;
  end

  assign rx_ld  = wr_en && (sel == SEL_RXCNT);
  assign tx_ld  = wr_en && (sel == SEL_TXCNT);
  assign rx_clr = wr_en && (sel == SEL_STAT) && wdata[CH_RX];
  assign tx_clr = wr_en && (sel == SEL_STAT) && wdata[CH_TX];

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_SOCK: begin
        rd_mux[SOCK_W-1:0]       = egress_q;
        rd_mux[SOCK_HI-1:SOCK_W] = ingress_q;
      end
      SEL_RXCNT: rd_mux = rx_cnt;
      SEL_TXCNT: rd_mux = tx_cnt;
      SEL_STAT: begin
        rd_mux[CH_RX] = rx_done;
        rd_mux[CH_TX] = tx_done;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      egress_q  <= '0;
      ingress_q <= '0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_SOCK) begin
        egress_q  <= wdata[SOCK_W-1:0];
        ingress_q <= wdata[SOCK_HI-1:SOCK_W];
      end
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign egress  = egress_q;
  assign ingress = ingress_q;
  assign rdata   = rdata_q;
  assign rvalid  = rvalid_q;
endmodule

// File: rtl/xfer_len_tracker.sv
module xfer_len_tracker
  import xlt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned SOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dma_mode,
  input  logic              rx_byte_stb,
  input  logic              tx_byte_stb,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              reg_rvalid,
  output logic [SOCK_W-1:0] egress_sock,
  output logic [SOCK_W-1:0] ingress_sock,
  output logic              rx_allow,
  output logic              tx_allow,
  output logic              rx_done,
  output logic              tx_done
);
  logic [N_CH-1:0]  stb_v, ld_v, clr_v, done_v, allow_v;
  logic [CNT_W-1:0] cnt_v [N_CH];

  assign stb_v[CH_RX] = rx_byte_stb;
  assign stb_v[CH_TX] = tx_byte_stb;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    xlt_chan #(.CNT_W(CNT_W)) chan_i (
      .clk      (clk),
      .rst      (rst),
      .dma_mode (dma_mode),
      .byte_stb (stb_v[g]),
      .ld_en    (ld_v[g]),
      .ld_val   (reg_wdata),
      .clr_done (clr_v[g]),
      .cnt      (cnt_v[g]),
      .done     (done_v[g]),
      .allow    (allow_v[g])
    );
  end

  xlt_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SOCK_W(SOCK_W)) regif_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .rd_en   (reg_rd_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rx_cnt  (cnt_v[CH_RX]),
    .tx_cnt  (cnt_v[CH_TX]),
    .rx_done (done_v[CH_RX]),
    .tx_done (done_v[CH_TX]),
    .rx_ld   (ld_v[CH_RX]),
    .tx_ld   (ld_v[CH_TX]),
    .rx_clr  (clr_v[CH_RX]),
    .tx_clr  (clr_v[CH_TX]),
    .egress  (egress_sock),
    .ingress (ingress_sock),
    .rdata   (reg_rdata),
    .rvalid  (reg_rvalid)
  );

  assign rx_allow = allow_v[CH_RX];
  assign tx_allow = allow_v[CH_TX];
  assign rx_done  = done_v[CH_RX];
  assign tx_done  = done_v[CH_TX];
endmodule

// File: rtl/xfer_len_tracker_chk.sv
module xfer_len_tracker_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             dma_mode,
  input logic             rx_stb,
  input logic             tx_stb,
  input logic             rx_ld,
  input logic             tx_ld,
  input logic             rx_clr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [CNT_W-1:0] tx_cnt,
  input logic             rx_done,
  input logic             tx_done,
  input logic             rx_allow,
  input logic             tx_allow
);
  localparam logic [CNT_W-1:0] ENDLESS = '1;

  // R2
  endless_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt == ENDLESS && !rx_ld) |=> (rx_cnt == ENDLESS));

  // R3
  rx_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && rx_stb && !rx_ld && rx_cnt != '0 && rx_cnt != ENDLESS)
      |=> (rx_cnt == $past(rx_cnt) - CNT_W'(1)));

  // R4
  rx_done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done) |-> ($past(rx_cnt) == CNT_W'(1) && rx_cnt == '0));

  // R4
  tx_done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> ($past(tx_cnt) == CNT_W'(1) && tx_cnt == '0));

  // R5
  no_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dma_mode && !tx_ld) |=> $stable(tx_cnt));

  // R6
  rx_load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ld |=> (rx_cnt == $past(wdata)));

  // R7
  rx_allow_chk: assert property (@(posedge clk) disable iff (rst)
    rx_allow == (rx_cnt != '0));

  // R7
  tx_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt == '0 && !tx_ld) |=> (tx_cnt == '0 && !tx_allow));

  // R8
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_clr && !(dma_mode && rx_stb && rx_cnt == CNT_W'(1))) |=> !rx_done);
endmodule

bind xfer_len_tracker xfer_len_tracker_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .dma_mode (dma_mode),
  .rx_stb   (rx_byte_stb),
  .tx_stb   (tx_byte_stb),
  .rx_ld    (ld_v[0]),
  .tx_ld    (ld_v[1]),
  .rx_clr   (clr_v[0]),
  .wdata    (reg_wdata),
  .rx_cnt   (cnt_v[0]),
  .tx_cnt   (cnt_v[1]),
  .rx_done  (rx_done),
  .tx_done  (tx_done),
  .rx_allow (rx_allow),
  .tx_allow (tx_allow)
);

// File: tb/xfer_len_tracker_tb_top.sv
`timescale 1ns/1ps
module xfer_len_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dma_mode = 1'b0;
  logic        rx_stb = 1'b0, tx_stb = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [7:0]  egress, ingress;
  logic        rx_allow, tx_allow, rx_done, tx_done;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  localparam logic [3:0] A_SOCK = 4'h0, A_RX = 4'h4, A_TX = 4'h8, A_ST = 4'hC;

  always #5 clk = ~clk;

  xfer_len_tracker dut_i (
    .clk(clk), .rst(rst), .dma_mode(dma_mode),
    .rx_byte_stb(rx_stb), .tx_byte_stb(tx_stb),
    .reg_wr_en(wr_en), .reg_rd_en(rd_en), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .reg_rvalid(rvalid),
    .egress_sock(egress), .ingress_sock(ingress),
    .rx_allow(rx_allow), .tx_allow(tx_allow),
    .rx_done(rx_done), .tx_done(tx_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // One clock with the given stimulus, applied at the falling edge.
  task automatic step(input bit wr, input logic [3:0] a, input logic [31:0] d,
                      input bit rs, input bit ts);
    @(negedge clk);
    wr_en = wr; addr = a; wdata = d; rx_stb = rs; tx_stb = ts;
    @(negedge clk);
    wr_en = 1'b0; rx_stb = 1'b0; tx_stb = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    if (rvalid !== 1'b1) begin
      n_fail++;
      $display("FAIL R10: rvalid actual %0b expected 1", rvalid);
    end
    n_chk++;
    v = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 flags", {28'h0, rx_allow, tx_allow, rx_done, tx_done}, 32'hC);
    chk("R1 sockets", {16'h0, ingress, egress}, 32'h0);
    rd(A_RX, v); chk("R1 rx count", v, 32'hFFFF_FFFF);
    rd(A_TX, v); chk("R1 tx count", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_socket();
    logic [31:0] v;
    wr(A_SOCK, 32'h0000_0603);
    chk("R9 egress", {24'h0, egress}, 32'h3);
    chk("R9 ingress", {24'h0, ingress}, 32'h6);
    wr(A_SOCK, 32'hABCD_0507);
    rd(A_SOCK, v); chk("R9 readback", v, 32'h0000_0507);
  endtask

  task automatic t_endless();
    logic [31:0] v;
    dma_mode = 1'b1;
    for (int i = 0; i < 5; i++) step(1'b0, A_SOCK, 0, 1'b1, 1'b1);
    rd(A_RX, v); chk("R2 rx endless", v, 32'hFFFF_FFFF);
    rd(A_TX, v); chk("R2 tx endless", v, 32'hFFFF_FFFF);
    chk("R2 no done", {30'h0, tx_done, rx_done}, 32'h0);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    dma_mode = 1'b0;
    wr(A_RX, 32'd3);
    step(1'b0, A_SOCK, 0, 1'b1, 1'b0);
    step(1'b0, A_SOCK, 0, 1'b1, 1'b0);
    rd(A_RX, v); chk("R5 non-DMA hold", v, 32'd3);
    dma_mode = 1'b1;
  endtask

  task automatic t_count_down();
    logic [31:0] v;
    step(1'b0, A_SOCK, 0, 1'b1, 1'b0);
    step(1'b0, A_SOCK, 0, 1'b1, 1'b0);
    rd(A_RX, v); chk("R3 two decrements", v, 32'd1);
    chk("R4 not done at 1", {31'h0, rx_done}, 32'h0);
    step(1'b0, A_SOCK, 0, 1'b1, 1'b0);
    chk("R4 done at 0", {31'h0, rx_done}, 32'h1);
    chk("R7 allow low", {31'h0, rx_allow}, 32'h0);
    step(1'b0, A_SOCK, 0, 1'b1, 1'b0);
    step(1'b0, A_SOCK, 0, 1'b1, 1'b0);
    rd(A_RX, v); chk("R7 no wrap", v, 32'd0);
    rd(A_ST, v); chk("R8 status rx bit", v, 32'h1);
    rd(A_TX, v); chk("R11 tx untouched", v, 32'hFFFF_FFFF);
    chk("R11 tx flags", {30'h0, tx_allow, tx_done}, 32'h2);
  endtask

  task automatic t_clear();
    wr(A_ST, 32'h0);
    chk("R8 write 0 keeps", {31'h0, rx_done}, 32'h1);
    wr(A_ST, 32'h2);
    chk("R11 tx clear leaves rx", {31'h0, rx_done}, 32'h1);
    wr(A_ST, 32'h1);
    chk("R8 write 1 clears", {31'h0, rx_done}, 32'h0);
  endtask

  task automatic t_load_vs_dec();
    logic [31:0] v;
    wr(A_TX, 32'd1);
    step(1'b1, A_TX, 32'd10, 1'b0, 1'b1);
    rd(A_TX, v); chk("R6 write wins", v, 32'd10);
    chk("R6 no done", {31'h0, tx_done}, 32'h0);
  endtask

  task automatic t_set_vs_clear();
    wr(A_TX, 32'd1);
    step(1'b1, A_ST, 32'h2, 1'b0, 1'b1);
    chk("R8 set beats clear", {31'h0, tx_done}, 32'h1);
    wr(A_ST, 32'h3);
    chk("R8 both cleared", {30'h0, tx_done, rx_done}, 32'h0);
  endtask

  task automatic t_sw_zero();
    wr(A_RX, 32'd0);
    chk("R4 sw zero no done", {31'h0, rx_done}, 32'h0);
    chk("R7 sw zero allow", {31'h0, rx_allow}, 32'h0);
    wr(A_RX, 32'd2);
    chk("R7 reload allow", {31'h0, rx_allow}, 32'h1);
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(A_TX, 32'd2);
    step(1'b0, A_SOCK, 0, 1'b1, 1'b1);
    rd(A_RX, v); chk("R11 rx after joint strobe", v, 32'd1);
    rd(A_TX, v); chk("R11 tx after joint strobe", v, 32'd1);
    step(1'b0, A_SOCK, 0, 1'b0, 1'b1);
    chk("R11 only tx done", {30'h0, tx_done, rx_done}, 32'h2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_socket();
    t_endless();
    t_mode();
    t_count_down();
    t_clear();
    t_load_vs_dec();
    t_set_vs_clear();
    t_sw_zero();
    t_both();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule